// File: doc/BRIEF.md
# Prescaled Two-Channel Interval Timer

This block is a register-mapped interval timer with a parameterized number of channels (two by default). All channels run from one functional clock. Each channel owns a control word, a sticky expiry flag, a 16-bit period register and a 16-bit up-counter. Firmware programs a period and a power-of-two clock divider, then sets the run bit. The counter advances on every divided tick. When the count reaches the period, the channel raises its flag and either restarts from zero (repeating mode) or stops and drops its own run bit (single-shot mode).

The register interface is a single-cycle synchronous port. A write is accepted on the clock edge where select and write are both high. Read data is combinational from the address. Every channel drives its own interrupt line. That line is high while the channel's flag is set and its interrupt enable is on.

Top module: `gptimer`

## Requirements
- R1: Channel n (n = 0..NCH-1) decodes at byte offsets 0x80·n+0x80 (control), +0x84 (flag), +0x88 (period), +0x8C (count). Control reads back bit 8 (interrupt enable), bit 5 (run), bit 4 (single-shot) and bits 3:0 (divider code), with all other bits zero. The period register reads back all 16 written bits.
- R2: An access that is not one of the mapped words reads 0 and a write to it changes nothing. The count register ignores writes.
- R3: After reset every register reads 0 and every interrupt line is low.
- R4: Divider code k in 0..8 produces one count tick every 2^k clocks. Codes 9..15 behave as code 8 (one tick per 256 clocks).
- R5: A control write that sets the run bit while it is clear zeroes the count and the divider phase. While the run bit is clear the count holds its value.
- R6: On a tick where the count equals the period, the flag (bit 0) sets and the count returns to 0. With divider code 0 and period L, the flag is set L+1 clocks after the enabling write edge. With code k it is set (L+1)·2^k clocks after that edge.
- R7: In repeating mode (bit 4 clear) the channel keeps running and expires every (L+1)·2^k clocks. A period of 0xFFFF gives 65536 ticks per expiry.
- R8: In single-shot mode the channel clears its own run bit on expiry and its count stays 0 afterwards.
- R9: Writing the flag register with bit 0 = 1 clears the flag. Bit 0 = 0 leaves it unchanged. An expiry in the same cycle as a clearing write leaves the flag set.
- R10: A channel's interrupt line is high exactly when its flag and its interrupt enable are both set.
- R11: Channels are independent: accesses to and expiry of one channel do not alter another channel's registers or interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock shared by all channels |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | AW (9) | Byte address |
| bus_wdata | input | DW (16) | Write data |
| bus_rdata | output | DW (16) | Read data for bus_addr, combinational |
| irq | output | NCH (2) | Per-channel interrupt request |

## Verification
The hardest situation to reach from the ports is an expiry that lands on the same clock edge as a flag-clearing write. The stimulus reaches it with a bench-side cycle counter: it starts a repeating channel, computes the clock of the next expiry from the period and divider, and issues the clearing write exactly one cycle earlier so that its edge coincides with the expiry. Clearing of the divider phase on restart is similarly hard to see. The bench stops a channel mid-phase, restarts it, and samples the count on the clock just before the first tick that a fresh phase would produce. The 16-bit full-wrap case is run through once in full.

// File: rtl/gptimer_pkg.sv
package gptimer_pkg;

    // Control word bit positions (decoded by firmware, kept fixed)
    localparam int CTRL_IEN_BIT = 8;
    localparam int CTRL_RUN_BIT = 5;
    localparam int CTRL_OS_BIT  = 4;
    localparam int PSC_W        = 4;

    // Word select inside a channel window, taken from address bits 3:2
    typedef enum logic [1:0] {
        RS_CTRL  = 2'd0,
        RS_FLAG  = 2'd1,
        RS_LOAD  = 2'd2,
        RS_COUNT = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic             ien;
        logic             run;
        logic             oneshot;
        logic [PSC_W-1:0] psc;
    } ctrl_t;

endpackage

// File: rtl/gptimer_prescaler.sv
module gptimer_prescaler
    import gptimer_pkg::*;
#(
    parameter int MAX_SHIFT = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clear,
    input  logic [PSC_W-1:0] psc,
    output logic             tick
);

    localparam int DIV_W = (MAX_SHIFT > 0) ? MAX_SHIFT : 1;

    logic [DIV_W-1:0] div_d, div_q;
    logic [DIV_W-1:0] mask;
    int               shift;

    // Reserved codes above MAX_SHIFT clamp to the slowest ratio
    always_comb begin
        shift = (int'(psc) > MAX_SHIFT) ? MAX_SHIFT : int'(psc);
        for (int b = 0; b < DIV_W; b++) begin
            mask[b] = (b < shift);
        end
    end

    assign tick = run && ((div_q & mask) == mask);

    always_comb begin
        div_d = div_q;
        if (clear) begin
            div_d = '0;
        end else if (run) begin
            div_d = div_q + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else begin
            div_q <= div_d;
        end
    end

endmodule

// File: rtl/gptimer_regdec.sv
module gptimer_regdec
    import gptimer_pkg::*;
#(
    parameter int NCH = 2,
    parameter int AW  = 9
) (
    input  logic [AW-1:0]   addr,
    output logic            hit,
    output logic [((NCH > 1) ? $clog2(NCH) : 1)-1:0] ch,
    output reg_sel_e        rsel
);

    localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1;

    logic [31:0] page;

    always_comb begin
        page = 32'(addr[AW-1:7]);
        hit  = (page >= 32'd1) && (page <= 32'(NCH))
            && (addr[6:4] == 3'b000) && (addr[1:0] == 2'b00);
        ch   = CH_W'(page - 32'd1);
        rsel = reg_sel_e'(addr[3:2]);
    end

endmodule

// File: rtl/gptimer_channel.sv
module gptimer_channel
    import gptimer_pkg::*;
#(
    parameter int DW        = 16,
    parameter int MAX_SHIFT = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_ctrl,
    input  logic          wr_flag,
    input  logic          wr_load,
    input  logic [DW-1:0] wdata,
    input  reg_sel_e      rsel,
    output logic [DW-1:0] rdata,
    output logic          irq,
    output logic          tick_o,
    output logic          expire_o,
    output logic          start_o,
    output logic          run_o,
    output logic          os_o,
    output logic          flag_o,
    output logic [DW-1:0] cnt_o
);

    typedef struct packed {
        ctrl_t         ctrl;
        logic [DW-1:0] load;
        logic [DW-1:0] cnt;
        logic          flag;
    } chan_st_t;

    chan_st_t st_d, st_q;
    logic     tick;
    logic     start;
    logic     expire;

    gptimer_prescaler #(
        .MAX_SHIFT (MAX_SHIFT)
    ) u_psc (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (st_q.ctrl.run),
        .clear (start),
        .psc   (st_q.ctrl.psc),
        .tick  (tick)
    );

    always_comb begin
        st_d   = st_q;
        start  = 1'b0;
        expire = 1'b0;

        if (wr_ctrl) begin
            st_d.ctrl.ien     = wdata[CTRL_IEN_BIT];
            st_d.ctrl.run     = wdata[CTRL_RUN_BIT];
            st_d.ctrl.oneshot = wdata[CTRL_OS_BIT];
            st_d.ctrl.psc     = wdata[PSC_W-1:0];
            start             = wdata[CTRL_RUN_BIT] && !st_q.ctrl.run;
        end

        if (wr_load) begin
            st_d.load = wdata;
        end

        if (wr_flag && wdata[0]) begin
            st_d.flag = 1'b0;
        end

        if (start) begin
            st_d.cnt = '0;
        end else if (tick) begin
            if (st_q.cnt == st_q.load) begin
                expire    = 1'b1;
                st_d.cnt  = '0;
                st_d.flag = 1'b1;
                if (st_q.ctrl.oneshot) begin
                    st_d.ctrl.run = 1'b0;
                end
            end else begin
                st_d.cnt = st_q.cnt + DW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rdata = '0;
        unique case (rsel)
            RS_CTRL: begin
                rdata[CTRL_IEN_BIT] = st_q.ctrl.ien;
                rdata[CTRL_RUN_BIT] = st_q.ctrl.run;
                rdata[CTRL_OS_BIT]  = st_q.ctrl.oneshot;
                rdata[PSC_W-1:0]    = st_q.ctrl.psc;
            end
            RS_FLAG:  rdata[0] = st_q.flag;
            RS_LOAD:  rdata    = st_q.load;
            RS_COUNT: rdata    = st_q.cnt;
            default:  rdata    = '0;
        endcase
    end

    assign irq      = st_q.flag && st_q.ctrl.ien;
    assign tick_o   = tick;
    assign expire_o = expire;
    assign start_o  = start;
    assign run_o    = st_q.ctrl.run;
    assign os_o     = st_q.ctrl.oneshot;
    assign flag_o   = st_q.flag;
    assign cnt_o    = st_q.cnt;

endmodule

// File: rtl/gptimer.sv
module gptimer
    import gptimer_pkg::*;
#(
    parameter int NCH       = 2,
    parameter int AW        = 9,
    parameter int DW        = 16,
    parameter int MAX_SHIFT = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bus_sel,
    input  logic           bus_wr,
    input  logic [AW-1:0]  bus_addr,
    input  logic [DW-1:0]  bus_wdata,
    output logic [DW-1:0]  bus_rdata,
    output logic [NCH-1:0] irq
);

    localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1;

    logic                    hit;
    logic [CH_W-1:0]         ch_idx;
    reg_sel_e                rsel;
    logic [NCH-1:0][DW-1:0]  ch_rdata;
    logic [NCH-1:0][DW-1:0]  ch_cnt;
    logic [NCH-1:0]          ch_tick;
    logic [NCH-1:0]          ch_expire;
    logic [NCH-1:0]          ch_start;
    logic [NCH-1:0]          ch_run;
    logic [NCH-1:0]          ch_os;
    logic [NCH-1:0]          ch_flag;

    gptimer_regdec #(
        .NCH (NCH),
        .AW  (AW)
    ) u_dec (
        .addr (bus_addr),
        .hit  (hit),
        .ch   (ch_idx),
        .rsel (rsel)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic go;
        assign go = bus_sel && bus_wr && hit && (ch_idx == CH_W'(i));

        gptimer_channel #(
            .DW        (DW),
            .MAX_SHIFT (MAX_SHIFT)
        ) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_ctrl  (go && (rsel == RS_CTRL)),
            .wr_flag  (go && (rsel == RS_FLAG)),
            .wr_load  (go && (rsel == RS_LOAD)),
            .wdata    (bus_wdata),
            .rsel     (rsel),
            .rdata    (ch_rdata[i]),
            .irq      (irq[i]),
            .tick_o   (ch_tick[i]),
            .expire_o (ch_expire[i]),
            .start_o  (ch_start[i]),
            .run_o    (ch_run[i]),
            .os_o     (ch_os[i]),
            .flag_o   (ch_flag[i]),
            .cnt_o    (ch_cnt[i])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NCH; i++) begin
            if (hit && (ch_idx == CH_W'(i))) begin
                bus_rdata = ch_rdata[i];
            end
        end
    end

endmodule

// File: rtl/gptimer_chk.sv
module gptimer_chk #(
    parameter int NCH = 2,
    parameter int DW  = 16
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [NCH-1:0]         irq,
    input logic [NCH-1:0]         flag,
    input logic [NCH-1:0]         tick,
    input logic [NCH-1:0]         expire,
    input logic [NCH-1:0]         start,
    input logic [NCH-1:0]         run,
    input logic [NCH-1:0]         os,
    input logic [NCH-1:0][DW-1:0] cnt
);

    for (genvar i = 0; i < NCH; i++) begin : g_a
        // R5: a stopped channel that is not being started keeps its count
        a_r5_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
            (!run[i] && !start[i]) |=> $stable(cnt[i]));

        // R5: starting zeroes the count and leaves the channel running
        a_r5_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
            start[i] |=> (cnt[i] == '0) && run[i]);

        // R5: a non-expiring tick advances the count by one
        a_r5_tick_advances: assert property (@(posedge clk) disable iff (!rst_n)
            (tick[i] && !expire[i]) |=> (cnt[i] == DW'($past(cnt[i]) + DW'(1))));

        // R6: expiry raises the flag and wraps the count
        a_r6_expire_flags: assert property (@(posedge clk) disable iff (!rst_n)
            expire[i] |=> flag[i] && (cnt[i] == '0));

        // R8: single-shot expiry drops the run bit
        a_r8_oneshot_stops: assert property (@(posedge clk) disable iff (!rst_n)
            (expire[i] && os[i]) |=> !run[i]);

        // R10: an interrupt is never raised without the flag
        a_r10_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
            irq[i] |-> flag[i]);
    end

endmodule

bind gptimer gptimer_chk #(
    .NCH (NCH),
    .DW  (DW)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .irq    (irq),
    .flag   (ch_flag),
    .tick   (ch_tick),
    .expire (ch_expire),
    .start  (ch_start),
    .run    (ch_run),
    .os     (ch_os),
    .cnt    (ch_cnt)
);

// File: tb/gptimer_tb.sv
module gptimer_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NCH = 2;
    localparam int AW  = 9;
    localparam int DW  = 16;
    localparam int NVEC = 16;

    // {write, addr[8:0], data[15:0]}; reads compare against data
    localparam logic [25:0] VEC [NVEC] = '{
        {1'b1, 9'h080, 16'hFFDF},
        {1'b0, 9'h080, 16'h011F},
        {1'b1, 9'h080, 16'h0117},
        {1'b0, 9'h080, 16'h0117},
        {1'b1, 9'h080, 16'h0000},
        {1'b1, 9'h088, 16'hA5C3},
        {1'b0, 9'h088, 16'hA5C3},
        {1'b1, 9'h108, 16'h1234},
        {1'b0, 9'h108, 16'h1234},
        {1'b1, 9'h08C, 16'h5555},
        {1'b0, 9'h08C, 16'h0000},
        {1'b1, 9'h090, 16'hFFFF},
        {1'b0, 9'h090, 16'h0000},
        {1'b0, 9'h088, 16'hA5C3},
        {1'b0, 9'h180, 16'h0000},
        {1'b0, 9'h08A, 16'h0000}
    };

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           bus_sel = 1'b0;
    logic           bus_wr = 1'b0;
    logic [AW-1:0]  bus_addr = '0;
    logic [DW-1:0]  bus_wdata = '0;
    logic [DW-1:0]  bus_rdata;
    logic [NCH-1:0] irq;

    int n_checks = 0;
    int n_errors = 0;
    int cyc = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    gptimer #(.NCH(NCH), .AW(AW), .DW(DW)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    function automatic logic [AW-1:0] ra(input int ch, input int off);
        return AW'(32'h80 * ch + 32'h80 + off);
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic bw(input logic [AW-1:0] a, input logic [DW-1:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rchk(input string tag, input logic [AW-1:0] a, input logic [DW-1:0] exp);
        logic [DW-1:0] v;
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        v = bus_rdata;
        bus_sel = 1'b0;
        chk(tag, 32'(v), 32'(exp));
    endtask

    task automatic wait_to(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        int e;
        int d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R3: reset state
        for (int c = 0; c < NCH; c++) begin
            for (int o = 0; o < 16; o += 4) rchk("R3 reset reg", ra(c, o), 16'h0);
        end
        chk("R3 reset irq", 32'(irq), 32'h0);

        // R1 and R2: register map vectors
        for (int k = 0; k < NVEC; k++) begin
            if (VEC[k][25]) bw(VEC[k][24:16], VEC[k][15:0]);
            else rchk("R1/R2 map vector", VEC[k][24:16], VEC[k][15:0]);
        end

        // R6 / R8 / R10: single-shot, period 3, divider 1, interrupt on
        bw(ra(0, 8), 16'd3);
        bw(ra(0, 0), 16'h0130);
        e = cyc;
        wait_to(e + 3);
        rchk("R6 count before expiry", ra(0, 12), 16'd3);
        rchk("R6 flag before expiry", ra(0, 4), 16'h0);
        chk("R10 irq before expiry", 32'(irq), 32'h0);
        wait_to(e + 4);
        rchk("R6 flag at expiry", ra(0, 4), 16'h1);
        rchk("R6 count wrapped", ra(0, 12), 16'h0);
        chk("R10 irq at expiry", 32'(irq), 32'h1);
        rchk("R8 run bit cleared", ra(0, 0), 16'h0110);
        wait_to(e + 12);
        rchk("R8 count stays zero", ra(0, 12), 16'h0);

        // R9: write-one-to-clear
        bw(ra(0, 4), 16'h0000);
        rchk("R9 zero write keeps flag", ra(0, 4), 16'h1);
        bw(ra(0, 4), 16'h0001);
        rchk("R9 one write clears flag", ra(0, 4), 16'h0);
        chk("R10 irq after clear", 32'(irq), 32'h0);

        // R10: gating by interrupt enable
        bw(ra(0, 8), 16'd1);
        bw(ra(0, 0), 16'h0030);
        e = cyc;
        wait_to(e + 2);
        rchk("R10 flag set masked", ra(0, 4), 16'h1);
        chk("R10 irq masked", 32'(irq), 32'h0);
        bw(ra(0, 0), 16'h0100);
        chk("R10 irq unmasked", 32'(irq), 32'h1);
        bw(ra(0, 4), 16'h0001);

        // R4: divider code 3, period 1 -> expiry at 16 clocks
        bw(ra(0, 0), 16'h0033);
        e = cyc;
        wait_to(e + 15);
        rchk("R4 code3 not yet", ra(0, 4), 16'h0);
        wait_to(e + 16);
        rchk("R4 code3 expiry", ra(0, 4), 16'h1);
        bw(ra(0, 4), 16'h0001);

        // R4: reserved code 9 acts as 256, period 0
        bw(ra(0, 8), 16'd0);
        bw(ra(0, 0), 16'h0039);
        e = cyc;
        wait_to(e + 255);
        rchk("R4 code9 not yet", ra(0, 4), 16'h0);
        wait_to(e + 256);
        rchk("R4 code9 expiry", ra(0, 4), 16'h1);
        bw(ra(0, 4), 16'h0001);

        // R7: repeating, code 2, period 2 -> every 12 clocks
        bw(ra(0, 8), 16'd2);
        bw(ra(0, 0), 16'h0022);
        e = cyc;
        wait_to(e + 11);
        rchk("R7 first not yet", ra(0, 4), 16'h0);
        wait_to(e + 12);
        rchk("R7 first expiry", ra(0, 4), 16'h1);
        rchk("R7 still running", ra(0, 0), 16'h0022);
        bw(ra(0, 4), 16'h0001);
        wait_to(e + 23);
        rchk("R7 second not yet", ra(0, 4), 16'h0);
        wait_to(e + 24);
        rchk("R7 second expiry", ra(0, 4), 16'h1);

        // R9: clear write on the same edge as the third expiry
        bw(ra(0, 4), 16'h0001);
        rchk("R9 cleared before race", ra(0, 4), 16'h0);
        wait_to(e + 35);
        bw(ra(0, 4), 16'h0001);
        rchk("R9 expiry beats clear", ra(0, 4), 16'h1);
        bw(ra(0, 0), 16'h0000);
        bw(ra(0, 4), 16'h0001);

        // R5: hold while stopped, restart clears count
        bw(ra(0, 8), 16'd100);
        bw(ra(0, 0), 16'h0020);
        e = cyc;
        wait_to(e + 7);
        rchk("R5 counting", ra(0, 12), 16'd7);
        bw(ra(0, 0), 16'h0000);
        d = cyc;
        wait_to(d + 5);
        rchk("R5 hold when stopped", ra(0, 12), 16'd8);
        bw(ra(0, 0), 16'h0020);
        e = cyc;
        rchk("R5 restart zeroes count", ra(0, 12), 16'd0);
        wait_to(e + 3);
        rchk("R5 counts after restart", ra(0, 12), 16'd3);

        // R5: restart clears the divider phase
        bw(ra(0, 0), 16'h0000);
        bw(ra(0, 0), 16'h0022);
        e = cyc;
        wait_to(e + 6);
        bw(ra(0, 0), 16'h0002);
        rchk("R5 phase run count", ra(0, 12), 16'd1);
        bw(ra(0, 0), 16'h0022);
        e = cyc;
        wait_to(e + 3);
        rchk("R5 phase reset no early tick", ra(0, 12), 16'd0);
        wait_to(e + 4);
        rchk("R5 phase reset first tick", ra(0, 12), 16'd1);
        bw(ra(0, 0), 16'h0000);

        // R7 / R11: full 16-bit wrap on channel 1
        bw(ra(1, 8), 16'hFFFF);
        bw(ra(1, 0), 16'h0120);
        e = cyc;
        wait_to(e + 65535);
        rchk("R7 wrap count top", ra(1, 12), 16'hFFFF);
        rchk("R7 wrap flag not yet", ra(1, 4), 16'h0);
        wait_to(e + 65536);
        rchk("R7 wrap expiry", ra(1, 4), 16'h1);
        rchk("R7 wrap count zero", ra(1, 12), 16'h0);
        chk("R11 irq only channel 1", 32'(irq), 32'h2);
        rchk("R11 channel 0 flag untouched", ra(0, 4), 16'h0);
        rchk("R11 channel 0 count untouched", ra(0, 12), 16'd1);
        bw(ra(0, 4), 16'h0001);
        rchk("R11 channel 1 flag kept", ra(1, 4), 16'h1);
        bw(ra(1, 0), 16'h0000);

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

endmodule